// File: doc/BRIEF.md
# DMA channel priority arbiter

This block decides which pending DMA channel the single transfer engine serves next. Every channel has a request-enable flag, a one-shot software start flag, a hardware request line, a priority value, a flag that allows the channel to be suspended, and an inverted flag that stops it from suspending others. A global mode input chooses between fixed-priority and rotating (round-robin) selection. Halt, halt-on-error and debug-stall controls can freeze the start of new work.

The engine sees a grant index with a valid flag, and pulses `minor_done` when the granted channel finishes its minor loop. In fixed-priority mode a running channel can be pre-empted. The block raises `suspend` for one cycle and records the interrupted channel in a single save slot. It then grants the pre-empting channel. When that channel completes, the saved channel competes again at its own priority, so it wins over any channel of lower priority.

The control is a three-state machine:
- `ST_IDLE`: no grant.
- `ST_BUSY`: grant valid.
- `ST_SUSP`: the one-cycle suspend.

Its transitions are:
- pick (`ST_IDLE` to `ST_BUSY`, when a candidate exists).
- finish (`ST_BUSY` to `ST_IDLE`, on `minor_done`).
- preempt (`ST_BUSY` to `ST_SUSP`).
- switch (`ST_SUSP` to `ST_BUSY`, granting the pre-empting channel).

Top module: `dma_chan_arbiter`

## Requirements
- R1: After reset `grant_vld`, `suspend`, `prio_err` and `halted` are 0, no channel has its request enabled and no software start is pending.
- R2: A channel is pending when its request enable is set and its `hw_req` bit is 1, or when it has a software start pending. In fixed mode (`cfg_rr`=0), the pending channel with the numerically largest priority is granted, and ties go to the lower index. From `ST_IDLE` the grant appears one clock edge after the candidate is visible. It drops at the edge that samples `minor_done`.
- R3: `en_set_vld` with `en_set_ch` sets that channel's request enable, and `en_clr_vld` with `en_clr_ch` clears it. Each takes effect at the next edge. `hw_req` of a channel whose enable is clear is ignored.
- R4: `start_vld` with `start_ch` makes that channel pending regardless of its enable. The start is consumed when the channel is granted, so it yields exactly one grant.
- R5: In round-robin mode (`cfg_rr`=1) the grant goes to the first pending channel found searching upward, with wrap, from the channel after the last one granted. The last granted channel is `NCH`-1 after reset.
- R6: In round-robin mode `suspend` is never raised.
- R7: In fixed mode, pre-emption happens when the running channel has `ch_preemptible`=1 and a pending channel has a strictly higher priority and `ch_no_preempt`=0. Then `suspend` is 1 and `grant_vld` is 0 for exactly one cycle, and the next cycle grants the pre-empting channel.
- R8: No pre-emption occurs when the candidate has `ch_no_preempt`=1, when the running channel has `ch_preemptible`=0, or while a pre-empted channel is still saved.
- R9: After the pre-empting channel finishes, the saved channel competes at its own priority and is granted ahead of pending channels of lower priority.
- R10: In fixed mode, `prio_err` rises one edge after two request-enabled channels share a priority value. It is never raised in round-robin mode.
- R11: Halt behaviour is as follows:
  - `halted` is `cfg_halt` OR a sticky error-halt flag.
  - The flag is set when `cfg_halt_on_err`=1 and either `err_in` or `prio_err` is 1.
  - The flag is cleared only by a `halt_clr` pulse.
  - While `halted` is 1, no new channel is started and no pre-emption occurs.
- R12: While `cfg_dbg`=1 no new channel is started. A channel already granted keeps its grant until `minor_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rr | input | 1 | 1 selects round-robin, 0 selects fixed priority |
| cfg_halt | input | 1 | Software halt |
| cfg_halt_on_err | input | 1 | Any error latches the halt |
| cfg_dbg | input | 1 | Debug stall of new channel starts |
| halt_clr | input | 1 | Pulse clearing the latched error halt |
| err_in | input | 1 | Error pulse from the transfer engine |
| ch_prio | input | NCH*PRIO_W | Per-channel priority, larger value wins |
| ch_preemptible | input | NCH | 1: channel may be suspended |
| ch_no_preempt | input | NCH | 1: channel may not suspend others |
| hw_req | input | NCH | Hardware request lines |
| en_set_vld | input | 1 | Set request enable command strobe |
| en_set_ch | input | CH_W | Channel for set command |
| en_clr_vld | input | 1 | Clear request enable command strobe |
| en_clr_ch | input | CH_W | Channel for clear command |
| start_vld | input | 1 | Software start command strobe |
| start_ch | input | CH_W | Channel for software start |
| minor_done | input | 1 | Granted channel finished its minor loop |
| grant_vld | output | 1 | Grant is valid |
| grant_ch | output | CH_W | Granted channel index |
| suspend | output | 1 | Suspend the running channel |
| prio_err | output | 1 | Duplicate priority among enabled channels |
| halted | output | 1 | Arbiter is halted |

## Verification
The hardest state to reach from the ports is a resume with contention. It needs a channel pre-empted and held in the save slot, the pre-empting channel still running, and a competitor of intermediate priority requesting when the pre-empting channel finishes. The stimulus first starts a low-index channel that has been given a raised priority and is marked suspendable. It then brings in a higher channel that is first blocked by its no-preempt flag, and releases that flag. While the higher channel runs, a channel of lower priority than the saved one starts requesting, so the bench can show that the resume wins and the competitor follows.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_SUSP = 2'd2
    } arb_state_e;
endpackage

// File: rtl/dma_arb_req.sv
// Per-channel request enables and one-shot software start flags.
module dma_arb_req #(
    parameter int NCH  = 8,
    parameter int CH_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_vld,
    input  logic [CH_W-1:0] set_ch,
    input  logic            clr_vld,
    input  logic [CH_W-1:0] clr_ch,
    input  logic            start_vld,
    input  logic [CH_W-1:0] start_ch,
    input  logic            take_vld,
    input  logic [CH_W-1:0] take_ch,
    input  logic [NCH-1:0]  hw_req,
    output logic [NCH-1:0]  req_en,
    output logic [NCH-1:0]  eff_req
);
    logic [NCH-1:0] en_q;
    logic [NCH-1:0] pend_q;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_q[g]   <= 1'b0;
                pend_q[g] <= 1'b0;
            end else begin
                if (clr_vld && clr_ch == CH_W'(g)) begin
                    en_q[g] <= 1'b0;
                end else if (set_vld && set_ch == CH_W'(g)) begin
                    en_q[g] <= 1'b1;
                end
                if (start_vld && start_ch == CH_W'(g)) begin
                    pend_q[g] <= 1'b1;
                end else if (take_vld && take_ch == CH_W'(g)) begin
                    pend_q[g] <= 1'b0;
                end
            end
        end
    end

    assign req_en  = en_q;
    assign eff_req = (en_q & hw_req) | pend_q;
endmodule

// File: rtl/dma_arb_fixed.sv
// Highest priority value wins; ties resolve to the lower index.
module dma_arb_fixed #(
    parameter int NCH    = 8,
    parameter int PRIO_W = 4,
    parameter int CH_W   = 3
) (
    input  logic [NCH-1:0]             cand,
    input  logic [NCH-1:0][PRIO_W-1:0] prio,
    output logic                       win_vld,
    output logic [CH_W-1:0]            win_ch,
    output logic [PRIO_W-1:0]          win_prio
);
    always_comb begin
        logic              v;
        logic [CH_W-1:0]   c;
        logic [PRIO_W-1:0] p;
        v = 1'b0;
        c = '0;
        p = '0;
        for (int i = 0; i < NCH; i++) begin
            if (cand[i] && (!v || prio[i] > p)) begin
                v = 1'b1;
                c = CH_W'(i);
                p = prio[i];
            end
        end
        win_vld  = v;
        win_ch   = c;
        win_prio = p;
    end
endmodule

// File: rtl/dma_arb_rr.sv
// Rotating search starting one above the last granted channel.
module dma_arb_rr #(
    parameter int NCH  = 8,
    parameter int CH_W = 3
) (
    input  logic [NCH-1:0]  cand,
    input  logic [CH_W-1:0] last,
    output logic            win_vld,
    output logic [CH_W-1:0] win_ch
);
    always_comb begin
        logic            v;
        logic [CH_W-1:0] c;
        v = 1'b0;
        c = '0;
        for (int k = 1; k <= NCH; k++) begin
            int idx;
            idx = (int'(last) + k) % NCH;
            if (!v && cand[idx]) begin
                v = 1'b1;
                c = CH_W'(idx);
            end
        end
        win_vld = v;
        win_ch  = c;
    end
endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter
    import dma_arb_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int PRIO_W = 4,
    localparam int CH_W  = $clog2(NCH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_rr,
    input  logic                       cfg_halt,
    input  logic                       cfg_halt_on_err,
    input  logic                       cfg_dbg,
    input  logic                       halt_clr,
    input  logic                       err_in,
    input  logic [NCH-1:0][PRIO_W-1:0] ch_prio,
    input  logic [NCH-1:0]             ch_preemptible,
    input  logic [NCH-1:0]             ch_no_preempt,
    input  logic [NCH-1:0]             hw_req,
    input  logic                       en_set_vld,
    input  logic [CH_W-1:0]            en_set_ch,
    input  logic                       en_clr_vld,
    input  logic [CH_W-1:0]            en_clr_ch,
    input  logic                       start_vld,
    input  logic [CH_W-1:0]            start_ch,
    input  logic                       minor_done,
    output logic                       grant_vld,
    output logic [CH_W-1:0]            grant_ch,
    output logic                       suspend,
    output logic                       prio_err,
    output logic                       halted
);
    arb_state_e        state_q, state_d;
    logic [CH_W-1:0]   cur_q, next_q, saved_q, last_q;
    logic              saved_vld_q, halt_err_q, prio_err_q;
    logic              take_vld;
    logic [CH_W-1:0]   take_ch;
    logic [NCH-1:0]    req_en, eff_req, saved_oh, cur_oh;
    logic [NCH-1:0]    cand_idle, cand_pre;
    logic              blocked, dup_prio, preempt_hit;
    logic              fx_vld, rr_vld, pre_vld, pick_vld;
    logic [CH_W-1:0]   fx_ch, rr_ch, pre_ch, pick_ch;
    logic [PRIO_W-1:0] fx_prio, pre_prio;

    dma_arb_req #(.NCH(NCH), .CH_W(CH_W)) u_req (
        .clk(clk), .rst_n(rst_n),
        .set_vld(en_set_vld), .set_ch(en_set_ch),
        .clr_vld(en_clr_vld), .clr_ch(en_clr_ch),
        .start_vld(start_vld), .start_ch(start_ch),
        .take_vld(take_vld), .take_ch(take_ch),
        .hw_req(hw_req), .req_en(req_en), .eff_req(eff_req)
    );

    assign halted    = cfg_halt | halt_err_q;
    assign blocked   = halted | cfg_dbg;
    assign saved_oh  = saved_vld_q ? (NCH'(1) << saved_q) : '0;
    assign cur_oh    = NCH'(1) << cur_q;
    // Halt and debug stall only let the interrupted channel come back.
    assign cand_idle = blocked ? saved_oh : (eff_req | saved_oh);
    assign cand_pre  = eff_req & ~cur_oh;

    dma_arb_fixed #(.NCH(NCH), .PRIO_W(PRIO_W), .CH_W(CH_W)) u_fix_idle (
        .cand(cand_idle), .prio(ch_prio),
        .win_vld(fx_vld), .win_ch(fx_ch), .win_prio(fx_prio)
    );

    dma_arb_fixed #(.NCH(NCH), .PRIO_W(PRIO_W), .CH_W(CH_W)) u_fix_pre (
        .cand(cand_pre), .prio(ch_prio),
        .win_vld(pre_vld), .win_ch(pre_ch), .win_prio(pre_prio)
    );

    dma_arb_rr #(.NCH(NCH), .CH_W(CH_W)) u_rr (
        .cand(cand_idle), .last(last_q),
        .win_vld(rr_vld), .win_ch(rr_ch)
    );

    assign pick_vld = cfg_rr ? rr_vld : fx_vld;
    assign pick_ch  = cfg_rr ? rr_ch  : fx_ch;

    assign preempt_hit = !cfg_rr && !blocked && !saved_vld_q && !minor_done
                      && ch_preemptible[cur_q] && pre_vld
                      && (pre_prio > ch_prio[cur_q]) && !ch_no_preempt[pre_ch];

    always_comb begin
        dup_prio = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            for (int j = i + 1; j < NCH; j++) begin
                if (req_en[i] && req_en[j] && ch_prio[i] == ch_prio[j]) begin
                    dup_prio = 1'b1;
                end
            end
        end
    end

    // Next state and grant hand-off.
    always_comb begin
        state_d  = state_q;
        take_vld = 1'b0;
        take_ch  = pick_ch;
        unique case (state_q)
            ST_IDLE: begin
                if (pick_vld) begin
                    state_d  = ST_BUSY;
                    take_vld = 1'b1;
                end
            end
            ST_BUSY: begin
                if (minor_done) begin
                    state_d = ST_IDLE;
                end else if (preempt_hit) begin
                    state_d = ST_SUSP;
                end
            end
            ST_SUSP: begin
                state_d  = ST_BUSY;
                take_vld = 1'b1;
                take_ch  = next_q;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            cur_q       <= '0;
            next_q      <= '0;
            saved_q     <= '0;
            saved_vld_q <= 1'b0;
            last_q      <= CH_W'(NCH - 1);
            halt_err_q  <= 1'b0;
            prio_err_q  <= 1'b0;
        end else begin
            state_q    <= state_d;
            prio_err_q <= !cfg_rr && dup_prio;
            if (take_vld) begin
                cur_q  <= take_ch;
                last_q <= take_ch;
            end
            if (state_q == ST_BUSY && !minor_done && preempt_hit) begin
                saved_q     <= cur_q;
                saved_vld_q <= 1'b1;
                next_q      <= pre_ch;
            end else if (state_q == ST_IDLE && take_vld && saved_vld_q
                         && take_ch == saved_q) begin
                saved_vld_q <= 1'b0;
            end
            if (halt_clr) begin
                halt_err_q <= 1'b0;
            end else if (cfg_halt_on_err && (err_in || prio_err_q)) begin
                halt_err_q <= 1'b1;
            end
        end
    end

    // Outputs.
    always_comb begin
        grant_vld = (state_q == ST_BUSY);
        grant_ch  = cur_q;
        suspend   = (state_q == ST_SUSP);
        prio_err  = prio_err_q;
    end

    assert_suspend_then_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        suspend |=> grant_vld);
    assert_suspend_no_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        suspend |-> !grant_vld);
    assert_rr_no_suspend_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY && cfg_rr) |=> !suspend);
    assert_halt_no_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && halted && !saved_vld_q) |=> !grant_vld);
    assert_dbg_no_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cfg_dbg && !saved_vld_q) |=> !grant_vld);
    assert_err_halt_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt_err_q) |-> $past(cfg_halt_on_err));
    assert_rr_no_prio_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rr |=> !prio_err);
endmodule

// File: tb/dma_chan_arbiter_tb.sv
module dma_chan_arbiter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCH    = 8;
    localparam int PRIO_W = 4;
    localparam int CH_W   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_rr = 0, cfg_halt = 0, cfg_halt_on_err = 0, cfg_dbg = 0;
    logic halt_clr = 0, err_in = 0;
    logic [NCH-1:0][PRIO_W-1:0] prio;
    logic [NCH-1:0] preemptible = '0, no_preempt = '0, hw_req = '0;
    logic en_set_vld = 0, en_clr_vld = 0, start_vld = 0, minor_done = 0;
    logic [CH_W-1:0] en_set_ch = '0, en_clr_ch = '0, start_ch = '0;
    logic grant_vld, suspend, prio_err, halted;
    logic [CH_W-1:0] grant_ch;
    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_chan_arbiter #(.NCH(NCH), .PRIO_W(PRIO_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_rr(cfg_rr), .cfg_halt(cfg_halt),
        .cfg_halt_on_err(cfg_halt_on_err), .cfg_dbg(cfg_dbg),
        .halt_clr(halt_clr), .err_in(err_in), .ch_prio(prio),
        .ch_preemptible(preemptible), .ch_no_preempt(no_preempt),
        .hw_req(hw_req), .en_set_vld(en_set_vld), .en_set_ch(en_set_ch),
        .en_clr_vld(en_clr_vld), .en_clr_ch(en_clr_ch),
        .start_vld(start_vld), .start_ch(start_ch), .minor_done(minor_done),
        .grant_vld(grant_vld), .grant_ch(grant_ch), .suspend(suspend),
        .prio_err(prio_err), .halted(halted)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_grant(input string tag, input int ch);
        chk({tag, " grant_vld"}, int'(grant_vld), 1);
        chk({tag, " grant_ch"}, int'(grant_ch), ch);
    endtask

    task automatic en_set(input int ch);
        en_set_vld = 1; en_set_ch = CH_W'(ch); tick(); en_set_vld = 0;
    endtask

    task automatic en_clr(input int ch);
        en_clr_vld = 1; en_clr_ch = CH_W'(ch); tick(); en_clr_vld = 0;
    endtask

    task automatic done_pulse();
        minor_done = 1; tick(); minor_done = 0;
    endtask

    task automatic t_reset();
        chk("R1 grant_vld", int'(grant_vld), 0);
        chk("R1 suspend", int'(suspend), 0);
        chk("R1 prio_err", int'(prio_err), 0);
        chk("R1 halted", int'(halted), 0);
        hw_req = '1; tick(); tick();
        chk("R1 no enables after reset", int'(grant_vld), 0);
        hw_req = '0;
    endtask

    task automatic t_fixed();
        en_set(0); en_set(2);
        hw_req[0] = 1; hw_req[2] = 1; tick();
        chk_grant("R2 highest prio first", 2);
        hw_req[2] = 0; done_pulse();
        chk("R2 grant drops on minor_done", int'(grant_vld), 0);
        tick();
        chk_grant("R2 next pending", 0);
        hw_req[0] = 0; done_pulse(); tick();
        chk("R2 idle with nothing pending", int'(grant_vld), 0);
        hw_req[7] = 1; tick(); tick();
        chk("R3 disabled channel ignored", int'(grant_vld), 0);
        hw_req[7] = 0;
        en_clr(2); hw_req[2] = 1; tick(); tick();
        chk("R3 cleared enable ignored", int'(grant_vld), 0);
        hw_req[2] = 0;
    endtask

    task automatic t_swstart();
        start_vld = 1; start_ch = 3'd6; tick(); start_vld = 0;
        tick();
        chk_grant("R4 software start", 6);
        done_pulse(); tick();
        chk("R4 start is one-shot", int'(grant_vld), 0);
    endtask

    task automatic t_err_halt();
        en_set(2);
        prio[3] = 4'd2; en_set(3); tick();
        chk("R10 duplicate priority flagged", int'(prio_err), 1);
        chk("R11 no halt without halt_on_err", int'(halted), 0);
        cfg_halt_on_err = 1; tick();
        chk("R11 error latches halt", int'(halted), 1);
        hw_req[0] = 1; tick(); tick();
        chk("R11 halted blocks start", int'(grant_vld), 0);
        prio[3] = 4'd3; tick();
        chk("R10 error clears when unique", int'(prio_err), 0);
        tick();
        chk("R11 halt is sticky", int'(halted), 1);
        halt_clr = 1; tick(); halt_clr = 0;
        chk("R11 halt_clr releases", int'(halted), 0);
        chk("R11 no grant same edge", int'(grant_vld), 0);
        tick();
        chk_grant("R11 start after release", 0);
        hw_req[0] = 0; done_pulse();
        err_in = 1; tick(); err_in = 0;
        chk("R11 engine error halts", int'(halted), 1);
        halt_clr = 1; tick(); halt_clr = 0;
        cfg_halt_on_err = 0;
        err_in = 1; tick(); err_in = 0;
        chk("R11 error ignored when disabled", int'(halted), 0);
        cfg_halt = 1; #1;
        chk("R11 software halt", int'(halted), 1);
        cfg_halt = 0;
        cfg_rr = 1; prio[3] = 4'd2; tick(); tick();
        chk("R10 no error in round-robin", int'(prio_err), 0);
        prio[3] = 4'd3; tick();
    endtask

    task automatic t_rr();
        en_set(5);
        preemptible = '1;
        hw_req[0] = 1; hw_req[2] = 1; hw_req[5] = 1; tick();
        chk_grant("R5 rotation from last+1", 2);
        done_pulse(); tick();
        chk_grant("R5 rotation second", 5);
        done_pulse(); tick();
        chk_grant("R5 rotation wraps", 0);
        tick(); tick();
        chk("R6 no suspend in round-robin", int'(suspend), 0);
        chk_grant("R6 grant kept", 0);
        done_pulse(); tick();
        chk_grant("R5 rotation back", 2);
        hw_req = '0; done_pulse();
        cfg_rr = 0; preemptible = '0; tick();
    endtask

    task automatic t_preempt();
        prio[0] = 4'd4; preemptible[0] = 1; no_preempt[5] = 1;
        hw_req[0] = 1; tick();
        chk_grant("R7 low channel runs", 0);
        hw_req[5] = 1; tick();
        chk("R8 no_preempt blocks suspend", int'(suspend), 0);
        chk_grant("R8 grant kept", 0);
        no_preempt[5] = 0; tick();
        chk("R7 suspend raised", int'(suspend), 1);
        chk("R7 grant low during suspend", int'(grant_vld), 0);
        tick();
        chk("R7 suspend one cycle", int'(suspend), 0);
        chk_grant("R7 preemptor granted", 5);
        hw_req[2] = 1; tick();
        chk_grant("R8 no nested preempt", 5);
        hw_req[5] = 0; done_pulse();
        chk("R9 idle after preemptor", int'(grant_vld), 0);
        tick();
        chk_grant("R9 saved channel resumes first", 0);
        hw_req[0] = 0; done_pulse(); tick();
        chk_grant("R9 lower channel after resume", 2);
        hw_req[5] = 1; tick(); tick();
        chk("R8 non-preemptible not suspended", int'(suspend), 0);
        chk_grant("R8 grant kept", 2);
        hw_req[2] = 0; done_pulse(); tick();
        chk_grant("R2 waiting channel served", 5);
        hw_req[5] = 0; done_pulse();
        prio[0] = 4'd0; preemptible = '0; tick();
    endtask

    task automatic t_debug();
        hw_req[2] = 1; tick();
        chk_grant("R12 start before debug", 2);
        cfg_dbg = 1; hw_req[3] = 1; tick();
        chk_grant("R12 running channel continues", 2);
        hw_req[2] = 0; done_pulse(); tick(); tick();
        chk("R12 new start stalled", int'(grant_vld), 0);
        cfg_dbg = 0; tick();
        chk_grant("R12 start after debug", 3);
        hw_req[3] = 0; done_pulse();
    endtask

    initial begin
        for (int i = 0; i < NCH; i++) prio[i] = PRIO_W'(i);
        repeat (3) @(negedge clk);
        rst_n = 1;
        tick();
        t_reset();
        t_fixed();
        t_swstart();
        t_err_halt();
        t_rr();
        t_preempt();
        t_debug();
        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule